// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a 32-bit core and a byte-addressed 32-bit data memory and moves narrow values onto and off the correct byte lanes. Memory is big endian: within a word, the byte at the lowest address sits in the most-significant lane. On the store side, the unit turns an access size and the two low address bits into four byte enables and a write word with the source value placed on the right lanes. On the load side, it picks the addressed byte or halfword out of the returned memory word and widens it to 32 bits, either by sign extension or by zero extension.

The unit is purely combinational. The core presents the size, the signed flag, the low address bits and either store data or memory read data. It takes the byte enables, write data, load result and a misalignment flag back in the same cycle. Address generation and the memory itself are outside the block. A misaligned access never reaches memory because every enable is held low.

Top module: `be_lane_unit`

## Requirements
- R1: Byte loads are big endian. Offset 0 selects read bits 31..24, offset 1 selects 23..16, offset 2 selects 15..8 and offset 3 selects 7..0.
- R2: A byte load with loadSigned=1 copies bit 7 of the selected byte into result bits 31..8. With loadSigned=0, those bits are zero.
- R3: A halfword load at offset 0 selects read bits 31..16 and at offset 2 selects bits 15..0. The result is sign-extended from bit 15 when loadSigned=1 and zero-extended when loadSigned=0.
- R4: A word load at offset 0 returns the read word unchanged for either value of loadSigned.
- R5: A byte store replicates storeData[7:0] into all four lanes of memWdata. It asserts exactly one enable: byteEn[3] for offset 0, down to byteEn[0] for offset 3.
- R6: A halfword store places storeData[15:0] in both halves of memWdata. It asserts byteEn=4'b1100 at offset 0 and 4'b0011 at offset 2.
- R7: A word store at offset 0 asserts byteEn=4'b1111 and passes storeData through unchanged.
- R8: A halfword access with address bit 0 set, or a word access at a nonzero offset, raises misalign, drives byteEn=4'b0000 and returns a zero load result.
- R9: A byte access is never misaligned at any offset.
- R10: Size encoding is accSize=2'b00 for byte, 2'b01 for halfword, and 2'b10 or 2'b11 for word. Both word codes behave identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| loadSigned | input | 1 | 1 selects sign extension for narrow loads |
| addrLow | input | 2 | Low two bits of the byte address |
| storeData | input | 32 | Source register value for stores |
| memRdata | input | 32 | Word returned by the data memory |
| byteEn | output | 4 | Per-lane write enables, bit 3 is the lowest address |
| memWdata | output | 32 | Lane-aligned write word |
| loadData | output | 32 | Selected and extended load result |
| misalign | output | 1 | Access violates its size alignment |

## Verification
The cases hardest to reach are those where two rules meet. One is a signed halfword load at offset 2, which must take its sign from bit 15 rather than bit 31. Another is a misaligned halfword whose enables must stay low even though the lane decode alone would pick two lanes. The stimulus uses read words whose bytes differ in sign, so picking the wrong lane or taking the sign from the wrong bit gives a different result. It then walks every size through all four offsets, with both values of the signed flag and both word encodings.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;

  // access size codes seen on accSize
  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } accSize_e;

  // strobes passed from the control decode to the lane datapath
  typedef struct packed {
    logic fault;
    logic selByte;
    logic selHalf;
    logic selWord;
    logic extSigned;
  } laneStrobe_t;

endpackage

// File: rtl/be_lane_ctrl.sv
module be_lane_ctrl
  import be_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [1:0]       accSize,
  input  logic             loadSigned,
  input  logic [OFF_W-1:0] addrLow,
  output laneStrobe_t      strobe
);

  accSize_e sizeCode;
  logic     isWord;
  logic     isHalf;
  logic     isByte;
  logic     wordBad;
  logic     halfBad;

  assign sizeCode = accSize_e'(accSize);

  always_comb begin
    isWord = 1'b0;
    isHalf = 1'b0;
    isByte = 1'b0;
    unique case (sizeCode)
      SZ_BYTE:             isByte = 1'b1;
      SZ_HALF:             isHalf = 1'b1;
      SZ_WORD, SZ_WORD_ALT: isWord = 1'b1;
      default:             isWord = 1'b1;
    endcase
  end

  // a word must sit on offset zero, a halfword on an even offset
  assign wordBad = isWord && (addrLow != '0);
  assign halfBad = isHalf && addrLow[0];

  always_comb begin
    strobe.fault     = wordBad | halfBad;
    strobe.selByte   = isByte;
    strobe.selHalf   = isHalf;
    strobe.selWord   = isWord;
    strobe.extSigned = loadSigned & ~isWord;
  end

endmodule

// File: rtl/be_lane_datapath.sv
module be_lane_datapath
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  laneStrobe_t       strobe,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HALVES = LANES / 2;
  localparam int HIDX_W = OFF_W - 1;

  logic [7:0]  byteAtOff [LANES];
  logic [15:0] halfAtIdx [HALVES];
  logic [7:0]  pickedByte;
  logic [15:0] pickedHalf;

  // store side: one slice per lane, lane k holds address offset LANES-1-k
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LADDR = LANES - 1 - k;
    localparam logic [OFF_W-1:0] LOFF = OFF_W'(LADDR);
    logic byteHit;
    logic halfHit;

    assign byteHit = strobe.selByte && (addrLow == LOFF);
    assign halfHit = strobe.selHalf && (addrLow[OFF_W-1:1] == LOFF[OFF_W-1:1]);
    assign byteEn[k] = ~strobe.fault & (byteHit | halfHit | strobe.selWord);

    always_comb begin
      if (strobe.selByte)
        memWdata[8*k +: 8] = storeData[7:0];
      else if (strobe.selHalf)
        memWdata[8*k +: 8] = storeData[8*(k % 2) +: 8];
      else
        memWdata[8*k +: 8] = storeData[8*k +: 8];
    end

    // load side: byte view indexed by address offset
    assign byteAtOff[LADDR] = memRdata[8*k +: 8];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halfAtIdx[HALVES-1-h] = memRdata[16*h +: 16];
  end

  assign pickedByte = byteAtOff[addrLow];
  assign pickedHalf = halfAtIdx[addrLow[OFF_W-1:1]];

  logic byteSign;
  logic halfSign;
  assign byteSign = strobe.extSigned & pickedByte[7];
  assign halfSign = strobe.extSigned & pickedHalf[15];

  always_comb begin
    if (strobe.fault)
      loadData = '0;
    else if (strobe.selByte)
      loadData = {{(DATA_W-8){byteSign}}, pickedByte};
    else if (strobe.selHalf)
      loadData = {{(DATA_W-16){halfSign}}, pickedHalf};
    else
      loadData = memRdata;
  end

  if (HIDX_W < 1) begin : g_width_guard
    initial $error("be_lane_datapath needs DATA_W of at least 32");
  end

endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]        accSize,
  input  logic              loadSigned,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              misalign
);

  laneStrobe_t strobe;

  be_lane_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .accSize   (accSize),
    .loadSigned(loadSigned),
    .addrLow   (addrLow),
    .strobe    (strobe)
  );

  be_lane_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe   (strobe),
    .addrLow  (addrLow),
    .storeData(storeData),
    .memRdata (memRdata),
    .byteEn   (byteEn),
    .memWdata (memWdata),
    .loadData (loadData)
  );

  assign misalign = strobe.fault;

endmodule

// File: rtl/be_lane_chk.sv
module be_lane_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic [1:0]        accSize,
  input logic              loadSigned,
  input logic [OFF_W-1:0]  addrLow,
  input logic [LANES-1:0]  byteEn,
  input logic [DATA_W-1:0] loadData,
  input logic              misalign
);

  logic known;
  assign known = !$isunknown({accSize, loadSigned, addrLow, byteEn, loadData, misalign});

  always_comb begin
    if (known) begin
      a_r8_fault_no_enables: assert (!misalign || (byteEn == '0 && loadData == '0))
        else $error("misaligned access drove enables or data");
      a_r9_byte_single_lane: assert (accSize != 2'b00 || (!misalign && $countones(byteEn) == 1))
        else $error("byte access not on exactly one lane");
      a_r6_half_two_lanes: assert (!(accSize == 2'b01 && !addrLow[0]) || $countones(byteEn) == 2)
        else $error("aligned halfword not on two lanes");
      a_r7_word_all_lanes: assert (!(accSize[1] && addrLow == '0) || (byteEn == '1 && !misalign))
        else $error("aligned word not on all lanes");
      a_r2_byte_zero_ext: assert (!(accSize == 2'b00 && !loadSigned) || loadData[DATA_W-1:8] == '0)
        else $error("unsigned byte load has high bits set");
      a_r3_half_sign_ext: assert (!(accSize == 2'b01 && loadSigned && !misalign) ||
                                  loadData[DATA_W-1:16] == {(DATA_W-16){loadData[15]}})
        else $error("signed halfword load not sign-extended");
    end
  end

endmodule

bind be_lane_unit be_lane_chk #(.DATA_W(DATA_W)) u_chk (
  .accSize   (accSize),
  .loadSigned(loadSigned),
  .addrLow   (addrLow),
  .byteEn    (byteEn),
  .loadData  (loadData),
  .misalign  (misalign)
);

// File: tb/be_lane_unit_tb.sv
module be_lane_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic        loadSigned = 1'b0;
  logic [1:0]  addrLow = 2'b00;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [3:0]  byteEn;
  logic [31:0] memWdata;
  logic [31:0] loadData;
  logic        misalign;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  be_lane_unit u_dut (
    .accSize(accSize), .loadSigned(loadSigned), .addrLow(addrLow),
    .storeData(storeData), .memRdata(memRdata),
    .byteEn(byteEn), .memWdata(memWdata), .loadData(loadData), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] sz, input logic sg, input logic [1:0] off,
                       input logic [31:0] sd, input logic [31:0] rd);
    @(negedge clk);
    accSize = sz; loadSigned = sg; addrLow = off; storeData = sd; memRdata = rd;
    #2;
  endtask

  // expected byte at offset, big-endian numbering
  function automatic logic [7:0] refByte(input logic [31:0] w, input int off);
    case (off)
      0: return w[31:24];
      1: return w[23:16];
      2: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic t_idle;
    chk("R5 idle enables", {28'd0, byteEn}, 32'h8);
    chk("R9 idle flag", {31'd0, misalign}, 32'd0);
    chk("R2 idle load", loadData, 32'd0);
  endtask

  task automatic t_byte_loads(input logic [31:0] w);
    for (int off = 0; off < 4; off++) begin
      for (int sg = 0; sg < 2; sg++) begin
        logic [7:0] b;
        logic [31:0] e;
        apply(2'b00, sg[0], off[1:0], 32'h0, w);
        b = refByte(w, off);
        e = (sg == 1 && b[7]) ? {24'hFFFFFF, b} : {24'h0, b};
        chk(sg == 1 ? "R2 signed byte load" : "R1 unsigned byte load", loadData, e);
        chk("R9 byte load aligned", {31'd0, misalign}, 32'd0);
      end
    end
  endtask

  task automatic t_half_loads(input logic [31:0] w);
    for (int hi = 0; hi < 2; hi++) begin
      for (int sg = 0; sg < 2; sg++) begin
        logic [15:0] h;
        logic [31:0] e;
        apply(2'b01, sg[0], hi == 0 ? 2'd0 : 2'd2, 32'h0, w);
        h = (hi == 0) ? w[31:16] : w[15:0];
        e = (sg == 1 && h[15]) ? {16'hFFFF, h} : {16'h0, h};
        chk("R3 halfword load", loadData, e);
      end
    end
  endtask

  task automatic t_word_load(input logic [31:0] w);
    for (int sg = 0; sg < 2; sg++) begin
      apply(2'b10, sg[0], 2'd0, 32'h0, w);
      chk("R4 word load", loadData, w);
      apply(2'b11, sg[0], 2'd0, 32'h0, w);
      chk("R10 alt word code load", loadData, w);
    end
  endtask

  task automatic t_byte_stores(input logic [31:0] d);
    for (int off = 0; off < 4; off++) begin
      apply(2'b00, 1'b0, off[1:0], d, 32'h0);
      chk("R5 byte store data", memWdata, {4{d[7:0]}});
      chk("R5 byte store enable", {28'd0, byteEn}, 32'(4'b1000 >> off));
    end
  endtask

  task automatic t_half_stores(input logic [31:0] d);
    apply(2'b01, 1'b0, 2'd0, d, 32'h0);
    chk("R6 half store data", memWdata, {2{d[15:0]}});
    chk("R6 half store enable off0", {28'd0, byteEn}, 32'hC);
    apply(2'b01, 1'b1, 2'd2, d, 32'h0);
    chk("R6 half store enable off2", {28'd0, byteEn}, 32'h3);
    chk("R6 half store aligned", {31'd0, misalign}, 32'd0);
  endtask

  task automatic t_word_store(input logic [31:0] d);
    apply(2'b10, 1'b0, 2'd0, d, 32'h0);
    chk("R7 word store data", memWdata, d);
    chk("R7 word store enable", {28'd0, byteEn}, 32'hF);
    apply(2'b11, 1'b0, 2'd0, d, 32'h0);
    chk("R10 alt word store enable", {28'd0, byteEn}, 32'hF);
  endtask

  task automatic t_misaligned;
    for (int off = 1; off < 4; off++) begin
      apply(2'b10, 1'b1, off[1:0], 32'hDEADBEEF, 32'h8899AABB);
      chk("R8 word misalign flag", {31'd0, misalign}, 32'd1);
      chk("R8 word misalign enables", {28'd0, byteEn}, 32'd0);
      chk("R8 word misalign load", loadData, 32'd0);
    end
    for (int off = 1; off < 4; off += 2) begin
      apply(2'b01, 1'b1, off[1:0], 32'h1234F00D, 32'hF0F08080);
      chk("R8 half misalign flag", {31'd0, misalign}, 32'd1);
      chk("R8 half misalign enables", {28'd0, byteEn}, 32'd0);
      chk("R8 half misalign load", loadData, 32'd0);
    end
  endtask

  initial begin
    #2000000;  // 100,000 cycles
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_idle();
    t_byte_loads(32'h817FC304);
    t_byte_loads(32'h00FF807E);
    t_half_loads(32'h80017FFE);
    t_half_loads(32'h7FFF8000);
    t_word_load(32'hCAFE0123);
    t_byte_stores(32'h123456A5);
    t_half_stores(32'hAABB9C3D);
    t_word_store(32'h0BADF00D);
    t_misaligned();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule